// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block handles the entry into an exception or trap handler for a processor whose local registers form a windowed stack. A small vector of exception requests and a separate trap request come in. When the sequencer is idle it grants the highest-priority request. It then saves the interrupted program counter, with the supervisor flag packed into bit 0, and the complete old status register into two consecutive local-register slots just above the current frame. It also produces the updated program counter and status register, which the core loads into its state.

The core supplies its current program counter and status register on `cur_pc` and `cur_sr`. It applies `new_pc` and `new_sr` on any clock edge where `commit_we` is high. The local register file is outside the block and is written through the single `rf_we`/`rf_waddr`/`rf_wdata` port. Handler entry addresses come in as inputs, one for each exception line and one for the trap.

Top module: `exc_entry_seq`

## Requirements
- R1: When several bits of `exc_req` are high in the cycle a request is accepted, only the lowest-numbered bit is granted. Bit 0 has the highest priority. The grant shows as a one-hot `exc_ack` pulse, and that line's entry address later appears on `new_pc`.
- R2: A request that was not granted is not lost. If the source keeps it high, it is granted by the next sequence after the current one completes.
- R3: `trap_req` is accepted only in a cycle with no `exc_req` bit high. A trap grant shows as a `trap_ack` pulse and uses `trap_vec_addr` as the new PC.
- R4: In the cycle after acceptance, `rf_we` is high. `rf_waddr` is FP + FL, and `rf_wdata` is the old PC with bit 0 replaced by the old S flag.
- R5: In the next cycle, `rf_we` is high. `rf_waddr` is FP + FL + 1, and `rf_wdata` is the old status register unchanged, including its instruction-length code.
- R6: A frame length of 0 counts as 16 in both save addresses and in the new FP. All addresses and FP wrap modulo 64.
- R7: In the same second cycle, `commit_we` is high and `new_pc` is the entry address. Status register layout: FP 31:26, FL 24:21, S 18, L 15, ILC 14:13, T 7, M 5, condition flags 3:0. In `new_sr`, S=1, L=1, M=0 and T=0. FP is the old FP plus the effective old FL. FL is 2 for an exception and 6 for a trap. Every other bit is copied from the old value.
- R8: `busy` is high for exactly the two write cycles. No request is granted while it is high, and in the cycle after the commit `busy`, `rf_we` and `commit_we` are low.
- R9: After a synchronous reset, `busy`, `rf_we`, `commit_we`, `exc_ack` and `trap_ack` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | NUM_EXC | Exception requests, bit 0 highest priority |
| trap_req | input | 1 | Trap-instruction entry request |
| exc_vec_addr | input | NUM_EXC*32 | Entry address per exception line, line i in bits 32i+31:32i |
| trap_vec_addr | input | 32 | Entry address for trap entry |
| cur_pc | input | 32 | Current program counter of the core |
| cur_sr | input | 32 | Current status register of the core |
| exc_ack | output | NUM_EXC | One-hot grant pulse for an exception line |
| trap_ack | output | 1 | Grant pulse for a trap |
| busy | output | 1 | Entry sequence in progress |
| rf_we | output | 1 | Local register write enable |
| rf_waddr | output | 6 | Local register write address |
| rf_wdata | output | 32 | Local register write data |
| commit_we | output | 1 | Core loads new_pc and new_sr at this edge |
| new_pc | output | 32 | Handler entry PC |
| new_sr | output | 32 | Updated status register |

## Verification
The assertions check on every cycle that grants are one-hot and go to the highest pending line, that a trap is granted only when no exception was pending, and that no grant occurs while busy. They also check that the two writes fall on consecutive cycles at consecutive addresses, that busy drops after the commit, and that the commit sets the control flags, selects the trap frame length and leaves the preserved status bits untouched. Only the directed scenarios show the exact save addresses and data for given FP and FL values: the FL=0 case, wrap-around at the top of the register file, and that a held lower-priority or mid-sequence request is serviced afterward.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int DATA_W = 32;
  localparam int RF_AW  = 6;
  localparam int FL_W   = 4;

  localparam int SR_COND_LSB = 0;
  localparam int SR_M        = 5;
  localparam int SR_T        = 7;
  localparam int SR_ILC_LSB  = 13;
  localparam int SR_L        = 15;
  localparam int SR_S        = 18;
  localparam int SR_FL_LSB   = 21;
  localparam int SR_FP_LSB   = DATA_W - RF_AW;

  localparam logic [FL_W-1:0] FL_EXC  = FL_W'(2);
  localparam logic [FL_W-1:0] FL_TRAP = FL_W'(6);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAVE_PC = 2'd1,
    ST_SAVE_SR = 2'd2
  } seq_state_e;

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int NUM_EXC = 4
) (
  input  logic [NUM_EXC-1:0] req,
  output logic [NUM_EXC-1:0] grant,
  output logic               any
);
  logic [NUM_EXC:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[NUM_EXC];
endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
  import exc_entry_pkg::*;
(
  input  logic [RF_AW-1:0] fp,
  input  logic [FL_W-1:0]  fl,
  output logic [RF_AW-1:0] addr_pc,
  output logic [RF_AW-1:0] addr_sr,
  output logic [RF_AW-1:0] fp_next
);
  logic [FL_W:0] fl_eff;

  always_comb begin
    if (fl == '0) fl_eff = (FL_W+1)'(1 << FL_W);
    else          fl_eff = {1'b0, fl};
  end

  assign addr_pc = fp + RF_AW'(fl_eff);
  assign addr_sr = addr_pc + RF_AW'(1);
  assign fp_next = addr_pc;
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
  import exc_entry_pkg::*;
(
  input  logic [DATA_W-1:0] old_sr,
  input  logic              is_trap,
  input  logic [RF_AW-1:0]  fp_next,
  output logic [DATA_W-1:0] upd_sr
);
  always_comb begin
    upd_sr                           = old_sr;
    upd_sr[SR_S]                     = 1'b1;
    upd_sr[SR_L]                     = 1'b1;
    upd_sr[SR_M]                     = 1'b0;
    upd_sr[SR_T]                     = 1'b0;
    upd_sr[SR_FL_LSB +: FL_W]        = is_trap ? FL_TRAP : FL_EXC;
    upd_sr[SR_FP_LSB +: RF_AW]       = fp_next;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int NUM_EXC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EXC-1:0]        exc_req,
  input  logic                      trap_req,
  input  logic [NUM_EXC*DATA_W-1:0] exc_vec_addr,
  input  logic [DATA_W-1:0]         trap_vec_addr,
  input  logic [DATA_W-1:0]         cur_pc,
  input  logic [DATA_W-1:0]         cur_sr,
  output logic [NUM_EXC-1:0]        exc_ack,
  output logic                      trap_ack,
  output logic                      busy,
  output logic                      rf_we,
  output logic [RF_AW-1:0]          rf_waddr,
  output logic [DATA_W-1:0]         rf_wdata,
  output logic                      commit_we,
  output logic [DATA_W-1:0]         new_pc,
  output logic [DATA_W-1:0]         new_sr
);
  seq_state_e state_q;

  logic [NUM_EXC-1:0] grant;
  logic               exc_any;
  logic               accept;
  logic               take_trap;
  logic [DATA_W-1:0]  entry_sel;
  logic [DATA_W-1:0]  pc_word;
  logic [RF_AW-1:0]   addr_pc, addr_sr, fp_next;
  logic [DATA_W-1:0]  upd_sr;

  logic [DATA_W-1:0]  sr_q;
  logic [DATA_W-1:0]  entry_q;
  logic [RF_AW-1:0]   addr_sr_q;
  logic [RF_AW-1:0]   fp_next_q;
  logic               trap_q;

  exc_prio_pick #(.NUM_EXC(NUM_EXC)) u_pick (
    .req   (exc_req),
    .grant (grant),
    .any   (exc_any)
  );

  exc_frame_calc u_frame (
    .fp      (cur_sr[SR_FP_LSB +: RF_AW]),
    .fl      (cur_sr[SR_FL_LSB +: FL_W]),
    .addr_pc (addr_pc),
    .addr_sr (addr_sr),
    .fp_next (fp_next)
  );

  exc_sr_update u_sr (
    .old_sr  (sr_q),
    .is_trap (trap_q),
    .fp_next (fp_next_q),
    .upd_sr  (upd_sr)
  );

  logic [DATA_W-1:0] vec_masked [NUM_EXC+1];
  assign vec_masked[0] = take_trap ? trap_vec_addr : '0;
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_vec
    assign vec_masked[i+1] = vec_masked[i] |
      (exc_vec_addr[i*DATA_W +: DATA_W] & {DATA_W{grant[i]}});
  end
  assign entry_sel = vec_masked[NUM_EXC];

  assign take_trap = trap_req & ~exc_any;
  assign accept    = (state_q == ST_IDLE) & (exc_any | trap_req);
  assign pc_word   = (cur_pc & ~DATA_W'(1)) | DATA_W'(cur_sr[SR_S]);
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      exc_ack   <= '0;
      trap_ack  <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      commit_we <= 1'b0;
      new_pc    <= '0;
      new_sr    <= '0;
      sr_q      <= '0;
      entry_q   <= '0;
      addr_sr_q <= '0;
      fp_next_q <= '0;
      trap_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          commit_we <= 1'b0;
          if (accept) begin
            state_q   <= ST_SAVE_PC;
            exc_ack   <= grant;
            trap_ack  <= take_trap;
            rf_we     <= 1'b1;
            rf_waddr  <= addr_pc;
            rf_wdata  <= pc_word;
            sr_q      <= cur_sr;
            entry_q   <= entry_sel;
            addr_sr_q <= addr_sr;
            fp_next_q <= fp_next;
            trap_q    <= take_trap;
          end else begin
            exc_ack  <= '0;
            trap_ack <= 1'b0;
            rf_we    <= 1'b0;
          end
        end
        ST_SAVE_PC: begin
          state_q   <= ST_SAVE_SR;
          exc_ack   <= '0;
          trap_ack  <= 1'b0;
          rf_we     <= 1'b1;
          rf_waddr  <= addr_sr_q;
          rf_wdata  <= sr_q;
          commit_we <= 1'b1;
          new_pc    <= entry_q;
          new_sr    <= upd_sr;
        end
        default: begin
          state_q   <= ST_IDLE;
          exc_ack   <= '0;
          trap_ack  <= 1'b0;
          rf_we     <= 1'b0;
          commit_we <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_entry_pkg::*;
#(
  parameter int NUM_EXC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EXC-1:0] exc_req,
  input logic               trap_req,
  input logic [NUM_EXC-1:0] exc_ack,
  input logic               trap_ack,
  input logic               busy,
  input logic               rf_we,
  input logic [RF_AW-1:0]   rf_waddr,
  input logic [DATA_W-1:0]  rf_wdata,
  input logic               commit_we,
  input logic [DATA_W-1:0]  new_sr
);
  localparam logic [DATA_W-1:0] CHANGED_MASK =
      (DATA_W'(1) << SR_S) | (DATA_W'(1) << SR_L) |
      (DATA_W'(1) << SR_M) | (DATA_W'(1) << SR_T) |
      (DATA_W'((1 << FL_W) - 1) << SR_FL_LSB) |
      (DATA_W'((1 << RF_AW) - 1) << SR_FP_LSB);

  logic                any_ack;
  logic [NUM_EXC-1:0]  lower_mask;
  assign any_ack    = (|exc_ack) | trap_ack;
  assign lower_mask = exc_ack - NUM_EXC'(1);

  a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_ack, trap_ack}));

  a_r1_highest_wins: assert property (@(posedge clk) disable iff (rst)
    (|exc_ack) |-> ((($past(exc_req) & exc_ack) != '0) &&
                    (($past(exc_req) & lower_mask) == '0)));

  a_r3_trap_only_clear: assert property (@(posedge clk) disable iff (rst)
    trap_ack |-> ($past(exc_req) == '0 && $past(trap_req)));

  a_r4_first_write: assert property (@(posedge clk) disable iff (rst)
    any_ack |-> (rf_we && busy && !commit_we));

  a_r5_second_write: assert property (@(posedge clk) disable iff (rst)
    any_ack |=> (rf_we && commit_we && rf_waddr == $past(rf_waddr) + RF_AW'(1)));

  a_r7_flags_set: assert property (@(posedge clk) disable iff (rst)
    commit_we |-> (new_sr[SR_S] && new_sr[SR_L] && !new_sr[SR_M] && !new_sr[SR_T]));

  a_r7_kept_bits: assert property (@(posedge clk) disable iff (rst)
    commit_we |-> (((new_sr ^ rf_wdata) & ~CHANGED_MASK) == '0));

  a_r7_trap_len: assert property (@(posedge clk) disable iff (rst)
    (commit_we && $past(trap_ack)) |-> (new_sr[SR_FL_LSB +: FL_W] == FL_TRAP));

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    commit_we |=> (!busy && !rf_we && !commit_we));

  a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
    any_ack |-> !$past(busy));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.NUM_EXC(NUM_EXC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .exc_req   (exc_req),
  .trap_req  (trap_req),
  .exc_ack   (exc_ack),
  .trap_ack  (trap_ack),
  .busy      (busy),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .rf_wdata  (rf_wdata),
  .commit_we (commit_we),
  .new_sr    (new_sr)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] exc_req = '0;
  logic          trap_req = 1'b0;
  logic [NE*32-1:0] exc_vec_addr;
  logic [31:0]   trap_vec_addr = 32'h0000_8000;
  logic [31:0]   cur_pc = '0;
  logic [31:0]   cur_sr = '0;
  logic [NE-1:0] exc_ack;
  logic          trap_ack, busy, rf_we, commit_we;
  logic [5:0]    rf_waddr;
  logic [31:0]   rf_wdata, new_pc, new_sr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < NE; i++) exc_vec_addr[i*32 +: 32] = 32'h0000_4000 + 32'(i) * 32'h100;
  end

  exc_entry_seq #(.NUM_EXC(NE)) u_dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .trap_req(trap_req),
    .exc_vec_addr(exc_vec_addr), .trap_vec_addr(trap_vec_addr),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .exc_ack(exc_ack), .trap_ack(trap_ack),
    .busy(busy), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .commit_we(commit_we), .new_pc(new_pc), .new_sr(new_sr)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_sr(logic [5:0] fp, logic [3:0] fl, logic s, logic [1:0] ilc);
    logic [31:0] v = 32'h0000_04AA;
    v[31:26] = fp; v[24:21] = fl; v[18] = s; v[14:13] = ilc;
    return v;
  endfunction

  task automatic run_entry(string nm, logic [NE-1:0] req, logic trp,
                           logic [NE-1:0] hold, logic [NE-1:0] raise_mid,
                           logic [31:0] pc, logic [31:0] sr);
    int idx = -1;
    logic [NE-1:0] e_ack = '0;
    logic [31:0] e_pc, e_sr;
    logic [5:0] fp = sr[31:26];
    logic [3:0] fl = sr[24:21];
    int fle = (fl == 0) ? 16 : int'(fl);
    logic [5:0] a0 = 6'((int'(fp) + fle) % 64);
    logic [5:0] a1 = a0 + 6'd1;
    for (int i = NE-1; i >= 0; i--) if (req[i]) idx = i;
    if (idx >= 0) begin
      e_ack[idx] = 1'b1;
      e_pc = 32'h0000_4000 + 32'(idx) * 32'h100;
    end else e_pc = trap_vec_addr;
    e_sr = sr; e_sr[18] = 1'b1; e_sr[15] = 1'b1; e_sr[5] = 1'b0; e_sr[7] = 1'b0;
    e_sr[24:21] = (idx < 0) ? 4'd6 : 4'd2; e_sr[31:26] = a0;
    cur_pc = pc; cur_sr = sr; exc_req = req; trap_req = trp;
    @(negedge clk);
    check("R1", {nm, " exc_ack"}, 64'(exc_ack), 64'(e_ack));
    check("R3", {nm, " trap_ack"}, 64'(trap_ack), 64'(idx < 0));
    check("R8", {nm, " busy first"}, 64'(busy), 64'd1);
    check("R4", {nm, " first we"}, 64'(rf_we), 64'd1);
    check("R6", {nm, " pc save addr"}, 64'(rf_waddr), 64'(a0));
    check("R4", {nm, " pc word"}, 64'(rf_wdata), 64'({pc[31:1], sr[18]}));
    check("R7", {nm, " no early commit"}, 64'(commit_we), 64'd0);
    exc_req = hold | raise_mid; trap_req = 1'b0;
    @(negedge clk);
    check("R5", {nm, " second we"}, 64'(rf_we), 64'd1);
    check("R5", {nm, " sr save addr"}, 64'(rf_waddr), 64'(a1));
    check("R5", {nm, " sr word"}, 64'(rf_wdata), 64'(sr));
    check("R7", {nm, " commit"}, 64'(commit_we), 64'd1);
    check("R7", {nm, " new_pc"}, 64'(new_pc), 64'(e_pc));
    check("R7", {nm, " new_sr"}, 64'(new_sr), 64'(e_sr));
    check("R8", {nm, " no grant while busy"}, 64'({exc_ack, trap_ack}), 64'd0);
    @(negedge clk);
    check("R8", {nm, " idle after"}, 64'({busy, rf_we, commit_we}), 64'd0);
    check("R8", {nm, " no grant at end"}, 64'({exc_ack, trap_ack}), 64'd0);
    cur_pc = e_pc; cur_sr = e_sr;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset outputs", 64'({busy, rf_we, commit_we, exc_ack, trap_ack}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // single request, odd PC
    run_entry("single", 4'b0100, 1'b0, 4'b0000, 4'b0000, 32'h1234_5679, mk_sr(6'd10, 4'd5, 1'b0, 2'd2));
    // R1 priority, R2 lower request stays pending
    run_entry("prio", 4'b1010, 1'b0, 4'b1000, 4'b0000, 32'h0000_0ABC, mk_sr(6'd20, 4'd3, 1'b1, 2'd1));
    run_entry("r2_pending", 4'b1000, 1'b0, 4'b0000, 4'b0000, cur_pc, cur_sr);
    run_entry("all", 4'b1111, 1'b0, 4'b0000, 4'b0000, 32'hFFFF_FFFF, mk_sr(6'd5, 4'd9, 1'b1, 2'd3));
    // R3 trap blocked by exception, then trap alone
    run_entry("r3_blocked", 4'b0100, 1'b1, 4'b0000, 4'b0000, 32'h0000_1110, mk_sr(6'd0, 4'd1, 1'b0, 2'd0));
    run_entry("r3_trap", 4'b0000, 1'b1, 4'b0000, 4'b0000, 32'h0000_2223, mk_sr(6'd40, 4'd7, 1'b0, 2'd2));
    // R6 FL=0 counts as 16 with wrap; R6 wrap between the two saves
    run_entry("r6_fl0", 4'b0001, 1'b0, 4'b0000, 4'b0000, 32'h0000_3000, mk_sr(6'd56, 4'd0, 1'b1, 2'd1));
    run_entry("r6_wrap", 4'b0010, 1'b0, 4'b0000, 4'b0000, 32'h0000_3004, mk_sr(6'd62, 4'd1, 1'b0, 2'd0));
    // R8 request raised during busy is taken only afterwards
    run_entry("r8_mid", 4'b0001, 1'b0, 4'b0000, 4'b0010, 32'h0000_5000, mk_sr(6'd30, 4'd4, 1'b0, 2'd3));
    run_entry("r8_after", 4'b0010, 1'b0, 4'b0000, 4'b0000, cur_pc, cur_sr);
    exc_req = '0;
    repeat (3) @(negedge clk);
    check("R8", "quiet with no request", 64'({busy, rf_we, commit_we}), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule